// File: doc/BRIEF.md
# Ganged Dual-Lane 256-bit Vector Execution Unit

This block executes a 256-bit vector micro-op as one operation by running two unlike 128-bit halves side by side. The low half runs on the integer SIMD datapath and the high half on the floating-point datapath. Both halves have the same fixed pipeline depth, so their results are merged and marked by a single valid strobe. Integer element add and multiply take the place of real floating-point arithmetic. Elements are 32 bits wide, and each 256-bit vector holds eight of them.

A separate lane-crossing network handles 256-bit shuffles. Each 128-bit half of its output can take any 128-bit half of either source, or zero. Narrow 128-bit operations occupy only the integer half. The floating-point half is left idle for those operations, and the upper half of their result is zero.

A scheduler drives one operation per cycle on `in_valid`, `in_op`, the two operands and the shuffle control. The result appears `LAT` cycles later, with `LAT` defaulting to 3.

Top module: `vgu_gang_unit`

## Requirements
- R1: An operation accepted with `in_valid` high at a rising edge produces `out_valid` high exactly after the third rising edge counting the accepting one. A new operation may be accepted on every cycle, back to back.
- R2: Opcode 0 (wide add) sets every 32-bit element i (bits 32i+31..32i, i = 0..7) to `in_a` element plus `in_b` element, modulo 2^32. No carry crosses an element boundary, including the boundary at bit 128.
- R3: Opcode 1 (wide multiply) sets every 32-bit element to the low 32 bits of the product of the matching elements of `in_a` and `in_b`.
- R4: For opcodes 0 and 1, the low 128 bits and the high 128 bits of the result complete in the same cycle and are marked by the same `out_valid` pulse.
- R5: Opcodes 3 (narrow add) and 4 (narrow multiply) compute only the low 128 bits, as in R2 and R3. Result bits 255..128 are zero and the high datapath is not used.
- R6: Opcode 2 (shuffle) builds each output half from `in_shuf`. Bits [1:0] select the source for the low half and bits [4:3] select the source for the high half, with 0 = `in_a` bits 127..0, 1 = `in_a` bits 255..128, 2 = `in_b` bits 127..0 and 3 = `in_b` bits 255..128. Bit 2 forces the low half to zero and bit 5 forces the high half to zero.
- R7: Opcodes 5, 6 and 7 are reserved. They still produce an `out_valid` pulse, with a result of all zeros.
- R8: While `rst_n` is low, `out_valid` is low, and operations that were in flight when reset was asserted are discarded.
- R9: An input cycle with `in_valid` low produces no `out_valid` pulse, whatever the operands and opcode, and the result bus reads zero in cycles where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Opcode (0 add, 1 mul, 2 shuffle, 3 narrow add, 4 narrow mul, 5-7 reserved) |
| in_a | input | 256 | Source vector A |
| in_b | input | 256 | Source vector B |
| in_shuf | input | 6 | Shuffle control: [1:0] low select, [2] low zero, [4:3] high select, [5] high zero |
| out_valid | output | 1 | Merged result valid |
| out_res | output | 256 | Merged 256-bit result |

## Verification
The hardest situation to reach is a reset that arrives while several different kinds of operation are still inside the pipeline. In that case none of them may emerge afterwards, and the halves must not be left out of step. The stimulus fills all three stages with back-to-back add, shuffle and narrow operations, drops reset for one cycle, and then checks the following cycles for silence. Carries that would leak across element boundaries, and in particular across bit 128 where the two datapaths meet, are rare under random operands. They are therefore forced with all-ones elements placed next to ones, before a long random run that mixes every opcode, shuffle control and idle cycle.

// File: rtl/vgu_pkg.sv
package vgu_pkg;

  localparam int ELEM_W     = 32;
  localparam int LANE_W     = 128;
  localparam int VEC_W      = 2 * LANE_W;
  localparam int LANE_ELEMS = LANE_W / ELEM_W;
  localparam int SHUF_W     = 6;

  typedef enum logic [2:0] {
    OP_ADD     = 3'd0,
    OP_MUL     = 3'd1,
    OP_SHUF    = 3'd2,
    OP_ADD_LO  = 3'd3,
    OP_MUL_LO  = 3'd4
  } vgu_op_e;

  // Shuffle control layout; bit positions are part of the interface.
  typedef struct packed {
    logic       hi_zero;
    logic [1:0] hi_sel;
    logic       lo_zero;
    logic [1:0] lo_sel;
  } shuf_ctl_t;

  // Element-wise wrap-around add over one 128-bit half.
  function automatic logic [LANE_W-1:0] lane_add(input logic [LANE_W-1:0] a,
                                                 input logic [LANE_W-1:0] b);
    logic [LANE_W-1:0] r;
    for (int e = 0; e < LANE_ELEMS; e++) begin
      r[e*ELEM_W +: ELEM_W] = a[e*ELEM_W +: ELEM_W] + b[e*ELEM_W +: ELEM_W];
    end
    return r;
  endfunction

  // Element-wise multiply keeping the low element-width bits of each product.
  function automatic logic [LANE_W-1:0] lane_mul(input logic [LANE_W-1:0] a,
                                                 input logic [LANE_W-1:0] b);
    logic [LANE_W-1:0] r;
    for (int e = 0; e < LANE_ELEMS; e++) begin
      r[e*ELEM_W +: ELEM_W] = a[e*ELEM_W +: ELEM_W] * b[e*ELEM_W +: ELEM_W];
    end
    return r;
  endfunction

  // Choose one 128-bit half out of the two 256-bit sources.
  function automatic logic [LANE_W-1:0] pick_half(input logic [VEC_W-1:0] a,
                                                  input logic [VEC_W-1:0] b,
                                                  input logic [1:0]       sel);
    logic [VEC_W-1:0] src;
    src = sel[1] ? b : a;
    return sel[0] ? src[VEC_W-1:LANE_W] : src[LANE_W-1:0];
  endfunction

endpackage

// File: rtl/vgu_delay.sv
module vgu_delay #(
  parameter int W   = 128,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);

  logic [LAT-1:0] v_q;
  logic [W-1:0]   d_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < LAT; i++) d_q[i] <= '0;
    end else begin
      v_q[0] <= in_v;
      d_q[0] <= in_v ? in_d : '0;
      for (int i = 1; i < LAT; i++) begin
        v_q[i] <= v_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign out_v = v_q[LAT-1];
  assign out_d = d_q[LAT-1];

  AST_DELAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_v |-> (out_d == '0)); // R9

endmodule

// File: rtl/vgu_half_lane.sv
module vgu_half_lane
  import vgu_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              use_mul,
  input  logic [LANE_W-1:0] opa,
  input  logic [LANE_W-1:0] opb,
  output logic              done,
  output logic [LANE_W-1:0] result
);

  logic [LANE_W-1:0] calc;

  always_comb begin
    calc = use_mul ? lane_mul(opa, opb) : lane_add(opa, opb);
  end

  vgu_delay #(.W(LANE_W), .LAT(LAT)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (en),
    .in_d  (calc),
    .out_v (done),
    .out_d (result)
  );

endmodule

// File: rtl/vgu_xlane_shuffle.sv
module vgu_xlane_shuffle
  import vgu_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  shuf_ctl_t        ctl,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic             done,
  output logic [VEC_W-1:0] result
);

  logic [LANE_W-1:0] lo_pick;
  logic [LANE_W-1:0] hi_pick;

  always_comb begin
    lo_pick = ctl.lo_zero ? '0 : pick_half(src_a, src_b, ctl.lo_sel);
    hi_pick = ctl.hi_zero ? '0 : pick_half(src_a, src_b, ctl.hi_sel);
  end

  vgu_delay #(.W(VEC_W), .LAT(LAT)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (en),
    .in_d  ({hi_pick, lo_pick}),
    .out_v (done),
    .out_d (result)
  );

endmodule

// File: rtl/vgu_gang_unit.sv
module vgu_gang_unit
  import vgu_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [VEC_W-1:0]  in_a,
  input  logic [VEC_W-1:0]  in_b,
  input  logic [SHUF_W-1:0] in_shuf,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_res
);

  // Issue decode
  logic lo_issue, hi_issue, shf_issue, mul_sel;

  always_comb begin
    lo_issue  = 1'b0;
    hi_issue  = 1'b0;
    shf_issue = 1'b0;
    mul_sel   = 1'b0;
    if (in_valid) begin
      case (in_op)
        OP_ADD:    begin lo_issue = 1'b1; hi_issue = 1'b1; end
        OP_MUL:    begin lo_issue = 1'b1; hi_issue = 1'b1; mul_sel = 1'b1; end
        OP_SHUF:   shf_issue = 1'b1;
        OP_ADD_LO: lo_issue = 1'b1;
        OP_MUL_LO: begin lo_issue = 1'b1; mul_sel = 1'b1; end
        default:   ;
      endcase
    end
  end

  // Named completion events
  logic              lo_done, hi_done, shf_done, retire_v;
  logic [LANE_W-1:0] lo_res, hi_res;
  logic [VEC_W-1:0]  shf_res;
  logic [0:0]        retire_tag;

  // Low half: integer SIMD datapath
  vgu_half_lane #(.LAT(LAT)) u_int_half (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (lo_issue),
    .use_mul (mul_sel),
    .opa     (in_a[LANE_W-1:0]),
    .opb     (in_b[LANE_W-1:0]),
    .done    (lo_done),
    .result  (lo_res)
  );

  // High half: floating-point datapath (integer stand-in arithmetic)
  vgu_half_lane #(.LAT(LAT)) u_fp_half (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (hi_issue),
    .use_mul (mul_sel),
    .opa     (in_a[VEC_W-1:LANE_W]),
    .opb     (in_b[VEC_W-1:LANE_W]),
    .done    (hi_done),
    .result  (hi_res)
  );

  vgu_xlane_shuffle #(.LAT(LAT)) u_xlane (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (shf_issue),
    .ctl    (shuf_ctl_t'(in_shuf)),
    .src_a  (in_a),
    .src_b  (in_b),
    .done   (shf_done),
    .result (shf_res)
  );

  // Retire strobe for every accepted op, reserved ones included
  vgu_delay #(.W(1), .LAT(LAT)) u_retire (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (in_valid),
    .in_d  (1'b1),
    .out_v (retire_v),
    .out_d (retire_tag)
  );

  logic [LANE_W-1:0] low_half, high_half;

  always_comb begin
    low_half  = '0;
    high_half = '0;
    if (lo_done)  low_half  = lo_res;
    if (hi_done)  high_half = hi_res;
    if (shf_done) begin
      low_half  = shf_res[LANE_W-1:0];
      high_half = shf_res[VEC_W-1:LANE_W];
    end
  end

  assign out_valid = retire_v & retire_tag[0];
  assign out_res   = {high_half, low_half};

  AST_HALVES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    hi_done |-> lo_done); // R4
  AST_SHUF_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    shf_done |-> !(lo_done || hi_done)); // R6
  AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_done || shf_done) |-> out_valid); // R1
  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_done && !hi_done) |-> (out_res[VEC_W-1:LANE_W] == '0)); // R5
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(lo_done || hi_done || shf_done)); // R9

endmodule

// File: tb/vgu_gang_unit_test.sv
module vgu_gang_unit_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   in_op = '0;
  logic [255:0] in_a = '0;
  logic [255:0] in_b = '0;
  logic [5:0]   in_shuf = '0;
  logic         out_valid;
  logic [255:0] out_res;

  always #2 clk = ~clk;

  vgu_gang_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_shuf   (in_shuf),
    .out_valid (out_valid),
    .out_res   (out_res)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  // Reference pipeline: index 1 newest, index 3 visible at the outputs
  bit           ev [1:3];
  logic [255:0] er [1:3];
  string        et [1:3];

  function automatic logic [255:0] ref_result(input logic [2:0] op, input logic [255:0] a,
                                              input logic [255:0] b, input logic [5:0] s);
    logic [255:0] r = '0;
    longint unsigned x, y;
    case (op)
      3'd0, 3'd1, 3'd3, 3'd4: begin
        for (int e = 0; e < 8; e++) begin
          if (e < 4 || op < 3'd3) begin
            x = a[e*32 +: 32];
            y = b[e*32 +: 32];
            if (op == 3'd0 || op == 3'd3) r[e*32 +: 32] = 32'((x + y) % 64'h1_0000_0000);
            else                          r[e*32 +: 32] = 32'((x * y) % 64'h1_0000_0000);
          end
        end
      end
      3'd2: begin
        for (int h = 0; h < 2; h++) begin
          int sel = (h == 0) ? int'(s[1:0]) : int'(s[4:3]);
          bit z   = (h == 0) ? s[2] : s[5];
          logic [127:0] piece;
          case (sel)
            0: piece = a[127:0];
            1: piece = a[255:128];
            2: piece = b[127:0];
            default: piece = b[255:128];
          endcase
          if (!z) r[h*128 +: 128] = piece;
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2 R4";
      3'd1: return "R3 R4";
      3'd2: return "R6";
      3'd3, 3'd4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // One clock: drive at negedge, let the edge happen, update model, compare.
  task automatic step(input bit v, input logic [2:0] op, input logic [255:0] a,
                      input logic [255:0] b, input logic [5:0] s);
    in_valid = v; in_op = op; in_a = a; in_b = b; in_shuf = s;
    @(posedge clk);
    @(negedge clk);
    if (!rst_n) begin
      for (int i = 1; i <= 3; i++) begin ev[i] = 0; er[i] = '0; et[i] = "R8"; end
    end else begin
      ev[3] = ev[2]; er[3] = er[2]; et[3] = et[2];
      ev[2] = ev[1]; er[2] = er[1]; et[2] = et[1];
      ev[1] = v;
      er[1] = v ? ref_result(op, a, b, s) : '0;
      et[1] = v ? tag_of(op) : "R9";
    end
    checks++;
    if (out_valid !== ev[3]) begin
      fails++;
      $display("FAIL R1 %s: out_valid=%b expected=%b", et[3], out_valid, ev[3]);
    end
    checks++;
    if (out_res !== er[3]) begin
      fails++;
      $display("FAIL %s: out_res=%h expected=%h", ev[3] ? et[3] : "R9", out_res, er[3]);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    logic [255:0] ca, cb;
    for (int i = 1; i <= 3; i++) begin ev[i] = 0; er[i] = '0; et[i] = "R8"; end

    // R8: reset holds outputs quiet even with valid input driven
    for (int i = 0; i < 3; i++) step(1, 3'd0, rnd256(), rnd256(), 6'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 3'd0, '0, '0, 6'd0);

    // R2/R4: carries must stop at each element, including bit 128
    ca = {8{32'hFFFF_FFFF}};
    cb = {8{32'h0000_0001}};
    step(1, 3'd0, ca, cb, 6'd0);
    ca = {32'h7FFF_FFFF, 32'h0, 32'h1, 32'h2, 32'hFFFF_FFFF, 32'h8000_0000, 32'h3, 32'h4};
    step(1, 3'd0, ca, ca, 6'd0);
    // R3: multiply with wide products
    step(1, 3'd1, {8{32'hFFFF_FFFF}}, {8{32'hFFFF_FFFF}}, 6'd0);
    step(1, 3'd1, {8{32'h0001_0000}}, {8{32'h0001_0001}}, 6'd0);
    // R6: every select for both halves and the zero flags
    ca = rnd256(); cb = rnd256();
    for (int s = 0; s < 64; s++) step(1, 3'd2, ca, cb, 6'(s));
    // R5: narrow ops leave the high half zero
    step(1, 3'd3, ca, cb, 6'd0);
    step(1, 3'd4, ca, cb, 6'd0);
    step(1, 3'd3, {8{32'hFFFF_FFFF}}, {8{32'h1}}, 6'd0);
    // R7: reserved opcodes give zero and still retire
    step(1, 3'd5, ca, cb, 6'h3F);
    step(1, 3'd6, ca, cb, 6'h3F);
    step(1, 3'd7, ca, cb, 6'h3F);
    // R9: idle cycles with junk operands
    for (int i = 0; i < 4; i++) step(0, 3'($urandom), rnd256(), rnd256(), 6'($urandom));

    // R8: reset while the pipeline holds mixed operations
    step(1, 3'd0, rnd256(), rnd256(), 6'd0);
    step(1, 3'd2, rnd256(), rnd256(), 6'h19);
    step(1, 3'd4, rnd256(), rnd256(), 6'd0);
    rst_n = 1'b0;
    step(1, 3'd1, rnd256(), rnd256(), 6'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 3'd0, '0, '0, 6'd0);

    // Random mix of all opcodes, controls and idle cycles
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, 3'($urandom), rnd256(), rnd256(), 6'($urandom));
    end
    for (int i = 0; i < 4; i++) step(0, 3'd0, '0, '0, 6'd0);

    finished = 1;
    summary();
    $finish;
  end

endmodule